// File: doc/BRIEF.md
# Dual-bank modular micro-op sequencer

This block is a small microcoded engine. It steps through a fixed program held in an internal ROM, and that program works on operands kept in two register banks of equal size, called LO and HI. The engine has micro-ops for copying a slot, loading an external word, storing a slot to the output, testing a slot for zero, and modular add, subtract and multiply. All arithmetic is done modulo a prime `P` of parameterised width. A counted loop runs one of two body micro-ops on each pass, chosen by the parity of the pass. This lets a run of squarings move back and forth between the banks with no copy steps in between.

The ROM is generated at elaboration from `P`. It computes the inverse square `x^-2` and the inverse cube `x^-3` of an input `x` by square-and-multiply on the exponent `P-3`. Runs of consecutive squarings are folded into loops. For `x = 0` every result is 0, because the value has no inverse and the chain simply gives zero.

A host sets `ext_in` and pulses `start` while the engine is idle. It collects the two stored results from `out_data`, waits for `done`, and can then read any slot through a word port that also accepts writes while the engine is idle.

Top module: `dbank_useq`

## Requirements
- R1: `start` is taken only while `busy` is low. `busy` rises at the clock edge that samples `start` and stays high until the halt micro-op runs. `done` is then high for exactly one cycle, and `busy` is low during that cycle.
- R2: Each run raises `out_valid` for exactly two single-cycle pulses. The first carries x^-2 mod P and the second carries x^-3 mod P, so that first·x² ≡ 1 and second·x³ ≡ 1 (mod P) for nonzero x.
- R3: After `done`, HI slot 3 holds x^-2 and HI slot 4 holds x^-3. LO slot 1 holds the loaded input, and HI slot 1 holds a copy of it.
- R4: After `done`, HI slot 6 holds (x^-2 + x^-3) mod P, produced by the add micro-op.
- R5: After `done`, HI slot 7 holds x^-2 − x^-3, with P added when the raw difference is negative.
- R6: Every arithmetic result lies in 0 … P−1. Multiplication is fully reduced.
- R7: `zflags` bit k belongs to slot k, for k = 0..3, in either bank. A zero-test of slot k sets bit k to 1 if the slot is zero and to 0 otherwise. A zero-test of slot 4 or above changes no bit. The program tests LO1, HI3 and LO5, so bits 1 and 3 equal (x == 0) and bits 0 and 2 remain 0.
- R8: A host write (`host_we`, bank 0 = LO and 1 = HI, slot, data) is stored only while idle and is ignored while busy. `host_rdata` shows the addressed slot combinationally.
- R9: A loop micro-op with count N runs N passes, starting with pass 0. Even passes run the first body op and odd passes run the second, and execution then goes on after the closing micro-op. A count of 0 skips the body. Odd-length loops must leave the accumulator in the bank the program expects, and this is visible in the R2 results.
- R10: For x = 0, both stored results and HI slots 3, 4, 6 and 7 are 0.
- R11: After reset, `busy`, `done`, `out_valid` and `zflags` are 0 and every slot reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a program run (idle only) |
| ext_in | input | W | Operand taken by the load micro-op |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse at program end |
| out_valid | output | 1 | Store micro-op result valid |
| out_data | output | W | Stored operand |
| zflags | output | 4 | Zero flags for slots 0..3 |
| host_we | input | 1 | Host slot write strobe |
| host_bank | input | 1 | Host bank select (0 LO, 1 HI) |
| host_slot | input | $clog2(NSLOT) | Host slot index |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Addressed slot contents |

## Verification
The range assertion on arithmetic results assumes that every operand entering the unit is already below P. That holds only if `ext_in` and any host-written value are reduced, so the stimulus draws inputs from 0 … P−1 and writes only small constants. The loop and handshake assertions assume the ROM is well formed. The stimulus mixes directed inputs (0, 1, 2, P−1) with seeded random inputs, and during some runs it drives a host write and a second `start` while busy to show that both are ignored.

// File: rtl/dbu_pkg.sv
package dbu_pkg;

   typedef enum logic [3:0] {
      OP_HALT   = 4'd0,
      OP_MOVE   = 4'd1,
      OP_CMPZ   = 4'd2,
      OP_CALC   = 4'd3,
      OP_LOAD   = 4'd4,
      OP_STOR   = 4'd5,
      OP_CYCLE  = 4'd6,
      OP_IFEVEN = 4'd7,
      OP_IFODD  = 4'd8,
      OP_REPEAT = 4'd9
   } op_e;

   typedef enum logic [1:0] {
      M_ADD = 2'd0,
      M_SUB = 2'd1,
      M_MUL = 2'd2
   } math_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RUN  = 2'd1,
      S_WAIT = 2'd2
   } seq_e;

   // loop counter width and flagged slot count
   localparam int CNTW   = 8;
   localparam int NFLAG  = 4;

   // slot roles used by the generated program
   localparam int SL_X    = 1;
   localparam int SL_ACC  = 2;
   localparam int SL_INV2 = 3;
   localparam int SL_INV3 = 4;
   localparam int SL_TMP  = 5;
   localparam int SL_SUM  = 6;
   localparam int SL_DIF  = 7;

endpackage

// File: rtl/dbu_rom.sv
module dbu_rom
   import dbu_pkg::*;
#(
   parameter int W     = 16,
   parameter int P     = 65521,
   parameter int SW    = 3,
   parameter int DEPTH = 64
) (
   input  logic [$clog2(DEPTH)-1:0] addr,
   output logic [3*SW+7:0]          word
);

   localparam int IW = 3*SW + 8;

   typedef logic [IW-1:0] prog_t [DEPTH];

   function automatic logic [IW-1:0] enc(logic [3:0] op, logic [1:0] m,
                                         logic sb, int s1, int s2,
                                         logic db, int d);
      return {op, m, sb, SW'(s1), SW'(s2), db, SW'(d)};
   endfunction

   function automatic logic [IW-1:0] enc_cyc(int k);
      logic [IW-1:0] w;
      w = '0;
      w[IW-1 -: 4] = OP_CYCLE;
      w[CNTW-1:0]  = CNTW'(k);
      return w;
   endfunction

   // square-and-multiply on exponent P-3, squaring runs folded into loops
   function automatic prog_t build();
      prog_t         pg;
      int            n;
      int            pend;
      int            t;
      logic          b;
      logic          hit;
      logic [W-1:0]  e;
      for (int i = 0; i < DEPTH; i++) pg[i] = '0;
      n = 0;
      e = W'(P - 3);
      pg[n] = enc(OP_LOAD, M_ADD, 1'b0, 0, 0, 1'b0, SL_X);       n++;
      pg[n] = enc(OP_CMPZ, M_ADD, 1'b0, SL_X, 0, 1'b0, 0);       n++;
      pg[n] = enc(OP_MOVE, M_ADD, 1'b0, SL_X, 0, 1'b1, SL_X);    n++;
      pg[n] = enc(OP_MOVE, M_ADD, 1'b0, SL_X, 0, 1'b0, SL_ACC);  n++;
      b = 1'b0;
      t = W - 1;
      while (t > 0 && !e[t]) t--;
      pend = 0;
      for (int i = t - 1; i >= -1; i--) begin
         hit = (i < 0) ? 1'b1 : e[(i < 0) ? 0 : i];
         if (i >= 0) pend++;
         if (hit) begin
            if (pend == 1) begin
               pg[n] = enc(OP_CALC, M_MUL, b, SL_ACC, SL_ACC, !b, SL_ACC); n++;
               b = !b;
            end else if (pend >= 2) begin
               pg[n] = enc_cyc(pend);                                          n++;
               pg[n] = enc(OP_IFEVEN, M_MUL, b, SL_ACC, SL_ACC, !b, SL_ACC);  n++;
               pg[n] = enc(OP_IFODD, M_MUL, !b, SL_ACC, SL_ACC, b, SL_ACC);   n++;
               pg[n] = enc(OP_REPEAT, M_ADD, 1'b0, 0, 0, 1'b0, 0);           n++;
               if (pend % 2 == 1) b = !b;
            end
            pend = 0;
            if (i >= 0) begin
               pg[n] = enc(OP_CALC, M_MUL, b, SL_ACC, SL_X, !b, SL_ACC); n++;
               b = !b;
            end
         end
      end
      pg[n] = enc(OP_MOVE, M_ADD, b, SL_ACC, 0, 1'b1, SL_INV2);               n++;
      pg[n] = enc(OP_CALC, M_MUL, 1'b1, SL_INV2, SL_INV2, 1'b0, SL_TMP);      n++;
      pg[n] = enc(OP_CALC, M_MUL, 1'b0, SL_TMP, SL_X, 1'b1, SL_INV3);         n++;
      pg[n] = enc(OP_CALC, M_ADD, 1'b1, SL_INV2, SL_INV3, 1'b1, SL_SUM);      n++;
      pg[n] = enc(OP_CALC, M_SUB, 1'b1, SL_INV2, SL_INV3, 1'b1, SL_DIF);      n++;
      pg[n] = enc(OP_CMPZ, M_ADD, 1'b1, SL_INV2, 0, 1'b0, 0);                 n++;
      pg[n] = enc(OP_CMPZ, M_ADD, 1'b0, SL_TMP, 0, 1'b0, 0);                  n++;
      pg[n] = enc(OP_STOR, M_ADD, 1'b1, SL_INV2, 0, 1'b0, 0);                 n++;
      pg[n] = enc(OP_STOR, M_ADD, 1'b1, SL_INV3, 0, 1'b0, 0);                 n++;
      pg[n] = enc(OP_HALT, M_ADD, 1'b0, 0, 0, 1'b0, 0);
      return pg;
   endfunction

   localparam prog_t PROG = build();

   assign word = PROG[addr];

endmodule

// File: rtl/dbu_banks.sv
module dbu_banks #(
   parameter int W     = 16,
   parameter int NSLOT = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic                     wbank,
   input  logic [$clog2(NSLOT)-1:0] wslot,
   input  logic [W-1:0]             wdata,
   input  logic                     ra_bank,
   input  logic [$clog2(NSLOT)-1:0] ra_slot,
   input  logic                     rb_bank,
   input  logic [$clog2(NSLOT)-1:0] rb_slot,
   input  logic                     rc_bank,
   input  logic [$clog2(NSLOT)-1:0] rc_slot,
   output logic [W-1:0]             ra,
   output logic [W-1:0]             rb,
   output logic [W-1:0]             rc
);

   logic [W-1:0] ra_v [2];
   logic [W-1:0] rb_v [2];
   logic [W-1:0] rc_v [2];

   for (genvar bk = 0; bk < 2; bk++) begin : g_bank
      logic [W-1:0] slots [NSLOT];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) slots[i] <= '0;
         end else if (we && (wbank == 1'(bk))) begin
            slots[wslot] <= wdata;
         end
      end

      assign ra_v[bk] = slots[ra_slot];
      assign rb_v[bk] = slots[rb_slot];
      assign rc_v[bk] = slots[rc_slot];
   end

   assign ra = ra_v[ra_bank];
   assign rb = rb_v[rb_bank];
   assign rc = rc_v[rc_bank];

endmodule

// File: rtl/dbu_alu.sv
module dbu_alu
   import dbu_pkg::*;
#(
   parameter int W          = 16,
   parameter int P          = 65521,
   parameter bit SERIAL_MUL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [1:0]   math,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         done,
   output logic [W-1:0] y
);

   localparam logic [W:0] PM = (W+1)'(P);

   function automatic logic [W-1:0] mod_add(logic [W-1:0] x, logic [W-1:0] z);
      logic [W:0] s;
      s = {1'b0, x} + {1'b0, z};
      if (s >= PM) s = s - PM;
      return s[W-1:0];
   endfunction

   function automatic logic [W-1:0] mod_sub(logic [W-1:0] x, logic [W-1:0] z);
      logic [W:0] s;
      if (x >= z) s = {1'b0, x} - {1'b0, z};
      else        s = {1'b0, x} + PM - {1'b0, z};
      return s[W-1:0];
   endfunction

   function automatic logic [W-1:0] addsub(logic [1:0] m, logic [W-1:0] x, logic [W-1:0] z);
      return (m == M_SUB) ? mod_sub(x, z) : mod_add(x, z);
   endfunction

   if (SERIAL_MUL) begin : g_serial
      localparam int CW = $clog2(W + 1);
      logic          m_busy;
      logic [CW-1:0] m_cnt;
      logic [W-1:0]  m_acc;
      logic [W-1:0]  m_a;
      logic [W-1:0]  m_b;
      logic [W-1:0]  step;

      always_comb begin
         step = mod_add(m_acc, m_acc);
         if (m_b[W-1]) step = mod_add(step, m_a);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_busy <= 1'b0;
            m_cnt  <= '0;
            m_acc  <= '0;
            m_a    <= '0;
            m_b    <= '0;
            y      <= '0;
            done   <= 1'b0;
         end else begin
            done <= 1'b0;
            if (go && !m_busy) begin
               if (math == M_MUL) begin
                  m_busy <= 1'b1;
                  m_cnt  <= CW'(W);
                  m_acc  <= '0;
                  m_a    <= a;
                  m_b    <= b;
               end else begin
                  y    <= addsub(math, a, b);
                  done <= 1'b1;
               end
            end else if (m_busy) begin
               m_acc <= step;
               m_b   <= m_b << 1;
               m_cnt <= m_cnt - 1'b1;
               if (m_cnt == CW'(1)) begin
                  m_busy <= 1'b0;
                  y      <= step;
                  done   <= 1'b1;
               end
            end
         end
      end
   end else begin : g_flat
      logic [2*W-1:0] prod;
      logic [2*W-1:0] red;
      assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      assign red  = prod % (2*W)'(P);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            y    <= '0;
            done <= 1'b0;
         end else begin
            done <= go;
            if (go) y <= (math == M_MUL) ? red[W-1:0] : addsub(math, a, b);
         end
      end
   end

   // R6: every delivered result is fully reduced
   a_r6_alu_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (y < PM[W-1:0]));

endmodule

// File: rtl/dbank_useq.sv
module dbank_useq
   import dbu_pkg::*;
#(
   parameter int W          = 16,
   parameter int P          = 65521,
   parameter int NSLOT      = 8,
   parameter int DEPTH      = 64,
   parameter bit SERIAL_MUL = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [W-1:0]             ext_in,
   output logic                     busy,
   output logic                     done,
   output logic                     out_valid,
   output logic [W-1:0]             out_data,
   output logic [NFLAG-1:0]         zflags,
   input  logic                     host_we,
   input  logic                     host_bank,
   input  logic [$clog2(NSLOT)-1:0] host_slot,
   input  logic [W-1:0]             host_wdata,
   output logic [W-1:0]             host_rdata
);

   localparam int SW    = $clog2(NSLOT);
   localparam int PCW   = $clog2(DEPTH);
   localparam int IW    = 3*SW + 8;
   localparam int F_DB  = SW;
   localparam int F_S2  = SW + 1;
   localparam int F_S1  = 2*SW + 1;
   localparam int F_SB  = 3*SW + 1;
   localparam int F_M   = 3*SW + 2;
   localparam int F_OP  = 3*SW + 4;

   // elaboration-time parameter checks
   if (NSLOT < 8 || (1 << SW) != NSLOT) begin : g_bad_slots
      $error("NSLOT must be a power of two, at least 8");
   end
   if ((1 << PCW) != DEPTH || DEPTH < 16 + 3*W) begin : g_bad_depth
      $error("DEPTH must be a power of two holding the generated program");
   end
   if (P < 5 || P % 2 == 0 || P >= (1 << W)) begin : g_bad_mod
      $error("P must be an odd prime in 5 .. 2**W-1");
   end
   if (3*SW + 1 < CNTW || W > 64) begin : g_bad_width
      $error("word layout cannot hold the loop count");
   end

   seq_e             st;
   logic [PCW-1:0]   pc;
   logic [IW-1:0]    ir;
   op_e              op;
   logic [1:0]       math;
   logic             sbank;
   logic [SW-1:0]    s1;
   logic [SW-1:0]    s2;
   logic             dbank;
   logic [SW-1:0]    dslot;
   logic [CNTW-1:0]  cnt_f;
   logic [CNTW-1:0]  loop_n;
   logic [CNTW-1:0]  loop_pass;
   logic [PCW-1:0]   loop_top;
   logic             skip_q;
   logic             more_passes;
   logic [W-1:0]     rd_a;
   logic [W-1:0]     rd_b;
   logic             alu_go;
   logic             alu_done;
   logic [W-1:0]     alu_y;
   logic             seq_we;
   logic [W-1:0]     seq_wd;
   logic             bk_we;
   logic             bk_wbank;
   logic [SW-1:0]    bk_wslot;
   logic [W-1:0]     bk_wdata;

   dbu_rom #(.W(W), .P(P), .SW(SW), .DEPTH(DEPTH)) u_rom (
      .addr (pc),
      .word (ir)
   );

   assign op    = op_e'(ir[F_OP +: 4]);
   assign math  = ir[F_M +: 2];
   assign sbank = ir[F_SB];
   assign s1    = ir[F_S1 +: SW];
   assign s2    = ir[F_S2 +: SW];
   assign dbank = ir[F_DB];
   assign dslot = ir[SW-1:0];
   assign cnt_f = ir[CNTW-1:0];

   assign more_passes = ({1'b0, loop_pass} + 1'b1) < {1'b0, loop_n};

   // operand write path: sequencer while running, host while idle
   always_comb begin
      seq_we = 1'b0;
      seq_wd = rd_a;
      if (st == S_RUN) begin
         if (op == OP_MOVE) seq_we = 1'b1;
         if (op == OP_LOAD) begin
            seq_we = 1'b1;
            seq_wd = ext_in;
         end
      end else if (st == S_WAIT && alu_done) begin
         seq_we = 1'b1;
         seq_wd = alu_y;
      end
   end

   assign bk_we    = seq_we | ((st == S_IDLE) & host_we);
   assign bk_wbank = (st == S_IDLE) ? host_bank  : dbank;
   assign bk_wslot = (st == S_IDLE) ? host_slot  : dslot;
   assign bk_wdata = (st == S_IDLE) ? host_wdata : seq_wd;

   dbu_banks #(.W(W), .NSLOT(NSLOT)) u_banks (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bk_we),
      .wbank   (bk_wbank),
      .wslot   (bk_wslot),
      .wdata   (bk_wdata),
      .ra_bank (sbank),
      .ra_slot (s1),
      .rb_bank (sbank),
      .rb_slot (s2),
      .rc_bank (host_bank),
      .rc_slot (host_slot),
      .ra      (rd_a),
      .rb      (rd_b),
      .rc      (host_rdata)
   );

   assign alu_go = (st == S_RUN) &&
                   ((op == OP_CALC) ||
                    (op == OP_IFEVEN && !loop_pass[0]) ||
                    (op == OP_IFODD  &&  loop_pass[0]));

   dbu_alu #(.W(W), .P(P), .SERIAL_MUL(SERIAL_MUL)) u_alu (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (alu_go),
      .math  (math),
      .a     (rd_a),
      .b     (rd_b),
      .done  (alu_done),
      .y     (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         pc        <= '0;
         loop_n    <= '0;
         loop_pass <= '0;
         loop_top  <= '0;
         skip_q    <= 1'b0;
         done      <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         zflags    <= '0;
      end else begin
         done      <= 1'b0;
         out_valid <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  pc <= '0;
                  st <= S_RUN;
               end
            end
            S_RUN: begin
               pc <= pc + 1'b1;
               case (op)
                  OP_HALT: begin
                     pc   <= pc;
                     st   <= S_IDLE;
                     done <= 1'b1;
                  end
                  OP_CMPZ: begin
                     if (s1 < SW'(NFLAG)) zflags[s1[1:0]] <= (rd_a == '0);
                  end
                  OP_STOR: begin
                     out_valid <= 1'b1;
                     out_data  <= rd_a;
                  end
                  OP_CALC: begin
                     pc     <= pc;
                     skip_q <= 1'b0;
                     st     <= S_WAIT;
                  end
                  OP_IFEVEN: begin
                     if (!loop_pass[0]) begin
                        pc     <= pc;
                        skip_q <= 1'b1;
                        st     <= S_WAIT;
                     end
                  end
                  OP_IFODD: begin
                     if (loop_pass[0]) begin
                        pc     <= pc;
                        skip_q <= 1'b0;
                        st     <= S_WAIT;
                     end
                  end
                  OP_CYCLE: begin
                     loop_n    <= cnt_f;
                     loop_pass <= '0;
                     loop_top  <= pc + 1'b1;
                     if (cnt_f == '0) pc <= pc + PCW'(4);
                  end
                  OP_REPEAT: begin
                     if (more_passes) begin
                        loop_pass <= loop_pass + 1'b1;
                        pc        <= loop_top;
                     end
                  end
                  default: ;
               endcase
            end
            S_WAIT: begin
               if (alu_done) begin
                  pc <= pc + (skip_q ? PCW'(2) : PCW'(1));
                  st <= S_RUN;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy = (st != S_IDLE);

   // R1: completion is a single pulse seen with the engine idle
   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R2: stores occur only inside a run
   a_r2_store_busy: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);
   // R9: the closing micro-op never sees a pass beyond the count
   a_r9_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RUN && op == OP_REPEAT) |-> (loop_pass < loop_n));
   // R7: flags move only while the program runs
   a_r7_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(zflags));

endmodule

// File: tb/dbank_useq_test.sv
`timescale 1ns/1ps
module dbank_useq_test;

   localparam int W     = 8;
   localparam int P     = 251;
   localparam int NSLOT = 8;
   localparam int SW    = 3;
   localparam logic [W-1:0] KEEP = 8'h3C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  ext_in = '0;
   logic          busy;
   logic          done;
   logic          out_valid;
   logic [W-1:0]  out_data;
   logic [3:0]    zflags;
   logic          host_we = 1'b0;
   logic          host_bank = 1'b0;
   logic [SW-1:0] host_slot = '0;
   logic [W-1:0]  host_wdata = '0;
   logic [W-1:0]  host_rdata;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   dbank_useq #(.W(W), .P(P), .NSLOT(NSLOT), .DEPTH(64), .SERIAL_MUL(1'b1)) uut (
      .clk (clk), .rst_n (rst_n), .start (start), .ext_in (ext_in),
      .busy (busy), .done (done), .out_valid (out_valid), .out_data (out_data),
      .zflags (zflags), .host_we (host_we), .host_bank (host_bank),
      .host_slot (host_slot), .host_wdata (host_wdata), .host_rdata (host_rdata)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int powm(int x, int e);
      longint r = 1;
      longint bse = x % P;
      int     k = e;
      while (k > 0) begin
         if (k % 2 == 1) r = (r * bse) % P;
         bse = (bse * bse) % P;
         k = k / 2;
      end
      return int'(r);
   endfunction

   task automatic hread(logic bank, int slot, output logic [W-1:0] v);
      host_bank = bank;
      host_slot = SW'(slot);
      #1 v = host_rdata;
   endtask

   task automatic hwrite(logic bank, int slot, logic [W-1:0] v);
      @(negedge clk);
      host_we = 1'b1; host_bank = bank; host_slot = SW'(slot); host_wdata = v;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic run_prog(int x, bit poke);
      int           nout = 0;
      bit           seen = 0;
      int           cyc = 0;
      logic [W-1:0] got [2];
      logic [W-1:0] v;
      int           e2, e3;
      got[0] = '0; got[1] = '0;
      e2 = powm(x, P - 3);
      e3 = powm(x, P - 4);
      @(negedge clk);
      ext_in = W'(x);
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 busy after start", busy, 1);
      while (!seen && cyc < 4000) begin
         if (out_valid) begin
            if (nout < 2) got[nout] = out_data;
            nout++;
         end
         if (done) begin
            seen = 1;
            chk("R1 busy low with done", busy, 0);
         end else begin
            chk("R1 busy held", busy, 1);
         end
         if (poke && cyc == 5) begin
            host_we = 1'b1; host_bank = 1'b0; host_slot = '0; host_wdata = 8'hA5;
            start = 1'b1;
         end else if (poke && cyc == 6) begin
            host_we = 1'b0;
            start = 1'b0;
         end
         cyc++;
         if (!seen) @(negedge clk);
      end
      chk("R1 done seen", seen, 1);
      @(negedge clk);
      chk("R1 done one cycle", done, 0);
      chk("R2 two stores", nout, 2);
      chk("R2 R9 inverse square", got[0], e2);
      chk("R2 inverse cube", got[1], e3);
      if (x != 0) begin
         chk("R2 square product", (got[0] * x % P) * x % P, 1);
         chk("R2 cube product", ((got[1] * x % P) * x % P) * x % P, 1);
      end else begin
         chk("R10 zero results", {got[0], got[1]}, 0);
      end
      chk("R6 range", (got[0] < P) && (got[1] < P), 1);
      hread(1'b1, 3, v); chk("R3 HI3", v, e2);
      hread(1'b1, 4, v); chk("R3 HI4", v, e3);
      hread(1'b0, 1, v); chk("R3 LO1", v, x);
      hread(1'b1, 1, v); chk("R3 HI1", v, x);
      hread(1'b1, 6, v); chk("R4 sum", v, (e2 + e3) % P);
      hread(1'b1, 7, v); chk("R5 difference", v, (e2 + P - e3) % P);
      chk("R7 flags", zflags, (x == 0) ? 4'b1010 : 4'b0000);
      hread(1'b0, 0, v); chk("R8 busy write ignored", v, KEEP);
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] v;
      void'($urandom(32'd20240611));
      #20;
      chk("R11 busy", busy, 0);
      chk("R11 done", done, 0);
      chk("R11 out_valid", out_valid, 0);
      chk("R11 zflags", zflags, 0);
      hread(1'b0, 0, v); chk("R11 LO0", v, 0);
      hread(1'b1, 7, v); chk("R11 HI7", v, 0);
      rst_n = 1'b1;
      hwrite(1'b0, 0, KEEP);
      hread(1'b0, 0, v); chk("R8 idle write", v, KEEP);
      hread(1'b1, 0, v); chk("R8 other bank untouched", v, 0);
      run_prog(0, 1'b1);
      run_prog(1, 1'b1);
      run_prog(P - 1, 1'b0);
      run_prog(2, 1'b1);
      run_prog(0, 1'b0);
      for (int i = 0; i < 120; i++) begin
         int x;
         x = int'($urandom_range(P - 1, 0));
         run_prog(x, (i % 3) == 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule